// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor Core

The block is a small synchronous processor core that executes thirteen 32-bit base-integer instructions: LUI, ADDI, ADD, SUB, AND, OR, XOR, LW, SW, BEQ, BNE, JAL and EBREAK. It completes every instruction in one clock cycle. In that cycle it fetches, decodes, reads the register file, computes, accesses data memory and writes back. It has 32 general registers, and register zero is wired to zero. It drives two terminal flags. One reports a normal stop at EBREAK. The other reports a fault.

Instructions and data use separate ports. Both ports are plain and have no handshake. Within the cycle, the instruction word must arrive combinationally for the fetch address, and load data must arrive combinationally for the data address. A store is presented as the data address, the data word and a write strobe, all in the same cycle. The attached memory writes on the clock edge that ends that cycle. Memories are indexed by address bits [31:2]. The core never stalls, so it places no back-pressure and expects none.

A fault is raised by an encoding outside the subset, a misaligned load or store address, or a misaligned target of a taken branch or a jump. The faulting instruction commits nothing: no register is written, no store is issued and the PC does not move. Both terminal flags stay set until reset. While either flag is set, the core is frozen.

Top module: `rvm_core`

## Requirements
- R1: While reset is low, the store strobe is low, and the fetch address and both flags read 0. Once reset rises, the first instruction is fetched from address 0.
- R2: EBREAK, recognised only as the exact word 0x00100073, sets the halt flag. It does not change the PC, the registers or memory.
- R3: Register zero reads as 0. Any write aimed at it by an ALU op, LUI, LW or JAL is dropped.
- R4: LUI, ADDI, ADD, SUB, AND, OR and XOR produce exact 32-bit results. ADDI sign-extends its 12-bit immediate. ADD and SUB differ only by funct7 = 0x00 versus 0x20.
- R5: LW and SW move a whole word at rs1 + sign-extended immediate. A store drives the address, the data and the strobe in the same cycle as its instruction.
- R6: BEQ and BNE advance the PC by 4 when not taken. When taken, they move it by the signed offset, forward or backward.
- R7: JAL writes PC + 4 to rd and jumps to PC + offset.
- R8: Any word outside the subset sets the fault flag. This includes a wrong funct3, a wrong funct7, an unknown opcode, and any system word other than 0x00100073. The faulting word writes no register and issues no store.
- R9: An LW or SW whose effective address has bits [1:0] not equal to 0 faults with no register write and no store. An effective address that is a multiple of 4 proceeds, even when the base and the offset are each misaligned.
- R10: A taken branch or a JAL whose target has bits [1:0] not equal to 0 faults without writing rd. A not-taken branch never faults on its target.
- R11: Once either flag is set, both flags hold, the fetch address holds and the store strobe stays low, until the next reset.
- R12: The fetch address is always word-aligned. Exactly one instruction retires per clock while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_addr | output | 32 | Byte address of the current instruction |
| fetch_word | input | 32 | Instruction word at fetch_addr, same cycle |
| mem_addr | output | 32 | Data byte address for load or store |
| mem_wdata | output | 32 | Store data |
| mem_wen | output | 1 | Store strobe; memory writes at the next rising edge |
| mem_rdata | input | 32 | Load data at mem_addr, same cycle |
| halted | output | 1 | Sticky normal stop after EBREAK |
| fault | output | 1 | Sticky fault flag |

## Verification
The bench builds the core with its default parameters: 32 registers and reset address 0. It attaches 64-word instruction and data arrays, so each program and every signature word fits in a small window that the bench can inspect entirely. At this size, a constant-loading program can be repeated for eight operand pairs, and every sum, difference and logic result is computed arithmetically in the bench. The same size also allows complete sweeps of near-miss illegal encodings and of aligned versus misaligned load, store, branch and jump cases, each followed by a freeze check on the fetch address and the store count.

// File: rtl/rvm_pkg.sv
package rvm_pkg;
  localparam int XLEN = 32;
  localparam int RF_FIELD_W = 5;

  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_SYS   = 7'b1110011;
  localparam logic [31:0] STOP_WORD = 32'h0010_0073;

  typedef enum logic [3:0] {
    OP_ILL, OP_LUI, OP_ADDI, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
    OP_LW, OP_SW, OP_BEQ, OP_BNE, OP_JAL, OP_STOP
  } op_e;

  typedef struct packed {
    op_e                   op;
    logic [RF_FIELD_W-1:0] rd;
    logic [RF_FIELD_W-1:0] rs1;
    logic [RF_FIELD_W-1:0] rs2;
    logic [XLEN-1:0]       imm;
  } dec_t;
endpackage

// File: rtl/rvm_decode.sv
module rvm_decode
  import rvm_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output dec_t            dec
);
  logic [2:0] f3;
  logic [6:0] f7;

  assign f3 = insn[14:12];
  assign f7 = insn[31:25];

  always_comb begin
    dec     = '0;
    dec.op  = OP_ILL;
    dec.rd  = insn[11:7];
    dec.rs1 = insn[19:15];
    dec.rs2 = insn[24:20];
    case (insn[6:0])
      OPC_LUI: begin
        dec.op  = OP_LUI;
        dec.imm = {insn[31:12], 12'b0};
      end
      OPC_IMM: begin
        dec.imm = {{20{insn[31]}}, insn[31:20]};
        if (f3 == 3'b000) dec.op = OP_ADDI;
      end
      OPC_REG: begin
        if (f7 == 7'h00) begin
          case (f3)
            3'b000:  dec.op = OP_ADD;
            3'b100:  dec.op = OP_XOR;
            3'b110:  dec.op = OP_OR;
            3'b111:  dec.op = OP_AND;
            default: dec.op = OP_ILL;
          endcase
        end else if (f7 == 7'h20 && f3 == 3'b000) begin
          dec.op = OP_SUB;
        end
      end
      OPC_LOAD: begin
        dec.imm = {{20{insn[31]}}, insn[31:20]};
        if (f3 == 3'b010) dec.op = OP_LW;
      end
      OPC_STORE: begin
        dec.imm = {{20{insn[31]}}, insn[31:25], insn[11:7]};
        if (f3 == 3'b010) dec.op = OP_SW;
      end
      OPC_BR: begin
        dec.imm = {{19{insn[31]}}, insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
        if (f3 == 3'b000) dec.op = OP_BEQ;
        else if (f3 == 3'b001) dec.op = OP_BNE;
      end
      OPC_JAL: begin
        dec.op  = OP_JAL;
        dec.imm = {{11{insn[31]}}, insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};
      end
      OPC_SYS: begin
        if (insn == STOP_WORD) dec.op = OP_STOP;
      end
      default: dec.op = OP_ILL;
    endcase
  end

  always_comb begin
    if (insn == STOP_WORD)
      AST_STOP_WORD_DECODES: assert (dec.op == OP_STOP); // R2
    if (insn[6:0] == OPC_REG && f7 != 7'h00 && f7 != 7'h20)
      AST_BAD_FUNCT7_ILLEGAL: assert (dec.op == OP_ILL); // R8
  end
endmodule

// File: rtl/rvm_regfile.sv
module rvm_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) bank[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : bank[ra1];
  assign rd2 = (ra2 == '0) ? '0 : bank[ra2];
endmodule

// File: rtl/rvm_alu.sv
module rvm_alu
  import rvm_pkg::*;
(
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      OP_LUI:  y = b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/rvm_core.sv
module rvm_core
  import rvm_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          NREG     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] fetch_addr,
  input  logic [31:0] fetch_word,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_wen,
  input  logic [31:0] mem_rdata,
  output logic        halted,
  output logic        fault
);
  localparam int RA_W = $clog2(NREG);

  logic [XLEN-1:0] pc_q;
  logic            halt_q, fault_q;
  dec_t            dec;
  logic [XLEN-1:0] rs1v, rs2v, alu_b, alu_y, target, link, wb_data, pc_next;
  logic            run, reg_src, writes_rd, is_mem, eq, taken;
  logic            mis_mem, mis_tgt, trap_now, stop_now, commit;

  rvm_decode u_dec (.insn(fetch_word), .dec(dec));

  rvm_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .we  (commit && writes_rd),
    .wa  (dec.rd[RA_W-1:0]),
    .wd  (wb_data),
    .ra1 (dec.rs1[RA_W-1:0]),
    .ra2 (dec.rs2[RA_W-1:0]),
    .rd1 (rs1v),
    .rd2 (rs2v)
  );

  assign reg_src = dec.op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
  assign alu_b   = reg_src ? rs2v : dec.imm;

  rvm_alu u_alu (.op(dec.op), .a(rs1v), .b(alu_b), .y(alu_y));

  assign run       = rst_n && !halt_q && !fault_q;
  assign writes_rd = dec.op inside {OP_LUI, OP_ADDI, OP_ADD, OP_SUB, OP_AND,
                                    OP_OR, OP_XOR, OP_LW, OP_JAL};
  assign is_mem    = dec.op inside {OP_LW, OP_SW};
  assign eq        = (rs1v == rs2v);
  assign taken     = (dec.op == OP_JAL) || (dec.op == OP_BEQ && eq) ||
                     (dec.op == OP_BNE && !eq);
  assign target    = pc_q + dec.imm;
  assign link      = pc_q + 32'd4;
  assign pc_next   = taken ? target : link;

  assign mis_mem  = is_mem && (alu_y[1:0] != 2'b00);
  assign mis_tgt  = taken && (target[1:0] != 2'b00);
  assign trap_now = run && (dec.op == OP_ILL || mis_mem || mis_tgt);
  assign stop_now = run && (dec.op == OP_STOP);
  assign commit   = run && !trap_now && !stop_now;

  always_comb begin
    case (dec.op)
      OP_LW:   wb_data = mem_rdata;
      OP_JAL:  wb_data = link;
      default: wb_data = alu_y;
    endcase
  end

  assign mem_addr   = alu_y;
  assign mem_wdata  = rs2v;
  assign mem_wen    = commit && (dec.op == OP_SW);
  assign fetch_addr = pc_q;
  assign halted     = halt_q;
  assign fault      = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      halt_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (commit)   pc_q    <= pc_next;
      if (stop_now) halt_q  <= 1'b1;
      if (trap_now) fault_q <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) AST_NO_STORE_IN_RESET: assert (!mem_wen); // R1
  end

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q || fault_q) |=> $stable(pc_q)); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q); // R11
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q); // R11
  AST_STOP_WORD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fetch_word == STOP_WORD) |=> (halt_q && $stable(pc_q))); // R2
  AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wen |-> (mem_addr[1:0] == 2'b00)); // R9
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[1:0] == 2'b00); // R12
endmodule

// File: tb/test_rvm_core.sv
`timescale 1ns/1ps
module test_rvm_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr, fetch_word, mem_addr, mem_wdata, mem_rdata;
  logic        mem_wen, halted, fault;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int n_chk = 0, n_fail = 0, n_st = 0, cyc_total = 0;

  always #2.5 clk = ~clk;

  assign fetch_word = imem[fetch_addr[7:2]];
  assign mem_rdata  = dmem[mem_addr[7:2]];

  rvm_core i_rvm_core (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wen(mem_wen),
    .mem_rdata(mem_rdata), .halted(halted), .fault(fault)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000) begin
        $display("FAIL watchdog act=%0d exp=<150000", cyc_total);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
        $finish;
      end
    end
  end

  function automatic logic [31:0] e_i(logic [31:0] imm, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm[11:0], rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] e_s(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] e_b(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] e_j(logic [31:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
  endfunction
  function automatic logic [31:0] addi(logic [4:0] rd, logic [4:0] rs1, logic [31:0] imm);
    return e_i(imm, rs1, 3'b000, rd, 7'h13);
  endfunction
  function automatic logic [31:0] lw(logic [4:0] rd, logic [4:0] rs1, logic [31:0] imm);
    return e_i(imm, rs1, 3'b010, rd, 7'h03);
  endfunction
  function automatic logic [31:0] sw(logic [4:0] rs2, logic [4:0] rs1, logic [31:0] imm);
    return e_s(imm, rs2, rs1, 3'b010);
  endfunction
  function automatic logic [31:0] lui(logic [4:0] rd, logic [31:0] v);
    return {v[31:12], rd, 7'h37};
  endfunction
  localparam logic [31:0] STOP = 32'h0010_0073;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (mem_wen) begin
      dmem[mem_addr[7:2]] = mem_wdata;
      n_st++;
    end
    @(negedge clk);
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'hA500_0000 | i;
    end
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R1 wen in reset", {31'b0, mem_wen}, 32'h0);
    end
    chk("R1 pc at reset", fetch_addr, 32'h0);
    chk("R1 flags at reset", {30'b0, halted, fault}, 32'h0);
  endtask

  task automatic go(output int cyc);
    rst_n = 1'b1;
    n_st = 0;
    cyc = 0;
    while (!halted && !fault && cyc < 300) begin
      step();
      cyc++;
    end
  endtask

  task automatic hold_check();
    logic [31:0] fa;
    int s;
    logic [1:0] fl;
    fa = fetch_addr;
    s = n_st;
    fl = {halted, fault};
    for (int i = 0; i < 6; i++) step();
    chk("R11 pc frozen", fetch_addr, fa);
    chk("R11 no stores", n_st, s);
    chk("R11 flags held", {30'b0, halted, fault}, {30'b0, fl});
  endtask

  task automatic load_const(input int slot, input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) & 32'hFFFF_F000;
    imem[slot]     = lui(rd, hi);
    imem[slot + 1] = addi(rd, rd, {{20{v[11]}}, v[11:0]});
  endtask

  initial begin
    int cyc;
    logic [31:0] a, b;
    logic [31:0] bad [11];
    logic [31:0] mw [9];
    logic mf [9];
    logic [31:0] m0 [9];
    @(negedge clk);

    // R1 R2: reset then a lone EBREAK
    begin_prog();
    imem[0] = STOP;
    go(cyc);
    chk("R2 halt after one cycle", cyc, 1);
    chk("R2 halted/fault", {30'b0, halted, fault}, 32'h2);
    chk("R1 R2 pc stays 0", fetch_addr, 32'h0);
    hold_check();

    // R4 R12: ALU sweep over eight operand pairs
    for (int k = 0; k < 8; k++) begin
      a = 32'h9E37_79B9 * (k + 1);
      b = {a[15:0], a[31:16]} ^ (32'h0101_0101 << k);
      begin_prog();
      load_const(0, 5'd1, a);
      load_const(2, 5'd2, b);
      imem[4]  = e_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3);
      imem[5]  = sw(5'd3, 5'd0, 0);
      imem[6]  = e_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd3);
      imem[7]  = sw(5'd3, 5'd0, 4);
      imem[8]  = e_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd3);
      imem[9]  = sw(5'd3, 5'd0, 8);
      imem[10] = e_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd3);
      imem[11] = sw(5'd3, 5'd0, 12);
      imem[12] = e_r(7'h00, 5'd2, 5'd1, 3'b100, 5'd3);
      imem[13] = sw(5'd3, 5'd0, 16);
      imem[14] = addi(5'd3, 5'd1, 32'hFFFF_F800);
      imem[15] = sw(5'd3, 5'd0, 20);
      imem[16] = lui(5'd3, a);
      imem[17] = sw(5'd3, 5'd0, 24);
      imem[18] = STOP;
      go(cyc);
      chk("R12 one insn per cycle", cyc, 19);
      chk("R4 ADD", dmem[0], a + b);
      chk("R4 SUB", dmem[1], a - b);
      chk("R4 AND", dmem[2], a & b);
      chk("R4 OR", dmem[3], a | b);
      chk("R4 XOR", dmem[4], a ^ b);
      chk("R4 ADDI negative", dmem[5], a - 32'd2048);
      chk("R4 LUI", dmem[6], a & 32'hFFFF_F000);
    end

    // R3: register zero
    begin_prog();
    imem[0] = addi(5'd1, 5'd0, 7);
    imem[1] = addi(5'd0, 5'd1, 5);
    imem[2] = lui(5'd0, 32'h1234_5000);
    imem[3] = e_r(7'h00, 5'd1, 5'd1, 3'b000, 5'd0);
    imem[4] = sw(5'd0, 5'd0, 0);
    imem[5] = e_r(7'h00, 5'd1, 5'd0, 3'b000, 5'd2);
    imem[6] = sw(5'd2, 5'd0, 4);
    imem[7] = lw(5'd0, 5'd0, 4);
    imem[8] = sw(5'd0, 5'd0, 8);
    imem[9] = STOP;
    go(cyc);
    chk("R3 x0 after ADDI/LUI/ADD", dmem[0], 32'h0);
    chk("R3 x0 read as zero", dmem[1], 32'd7);
    chk("R3 x0 after LW", dmem[2], 32'h0);

    // R5: word loads and stores
    begin_prog();
    imem[0] = addi(5'd1, 5'd0, 32);
    imem[1] = lw(5'd2, 5'd1, 4);
    imem[2] = lw(5'd3, 5'd1, 32'hFFFF_FFFC);
    imem[3] = sw(5'd2, 5'd1, 12);
    imem[4] = sw(5'd3, 5'd1, 32'hFFFF_FFE0);
    imem[5] = e_r(7'h00, 5'd3, 5'd2, 3'b000, 5'd4);
    imem[6] = sw(5'd4, 5'd0, 60);
    imem[7] = STOP;
    go(cyc);
    chk("R5 SW positive offset", dmem[11], 32'hA500_0009);
    chk("R5 SW negative offset", dmem[0], 32'hA500_0007);
    chk("R5 LW sum", dmem[15], 32'hA500_0009 + 32'hA500_0007);
    chk("R5 store count", n_st, 3);
    chk("R5 untouched word", dmem[9], 32'hA500_0009);

    // R6 R12: loop with backward, forward, taken and not-taken branches
    begin_prog();
    imem[0]  = addi(5'd1, 5'd0, 0);
    imem[1]  = addi(5'd2, 5'd0, 5);
    imem[2]  = addi(5'd1, 5'd1, 3);
    imem[3]  = addi(5'd2, 5'd2, 32'hFFFF_FFFF);
    imem[4]  = e_b(32'hFFFF_FFF8, 5'd0, 5'd2, 3'b001);
    imem[5]  = e_b(8, 5'd0, 5'd1, 3'b000);
    imem[6]  = e_b(8, 5'd0, 5'd2, 3'b000);
    imem[7]  = addi(5'd1, 5'd1, 100);
    imem[8]  = sw(5'd1, 5'd0, 0);
    imem[9]  = e_b(8, 5'd1, 5'd1, 3'b001);
    imem[10] = STOP;
    go(cyc);
    chk("R6 loop result", dmem[0], 32'd15);
    chk("R6 R12 cycle count", cyc, 22);
    chk("R6 final pc", fetch_addr, 32'd40);

    // R7: JAL link and target, forward and backward
    begin_prog();
    imem[0] = e_j(16, 5'd5);
    imem[1] = sw(5'd6, 5'd0, 4);
    imem[2] = sw(5'd1, 5'd0, 8);
    imem[3] = STOP;
    imem[4] = sw(5'd5, 5'd0, 0);
    imem[5] = addi(5'd1, 5'd0, 7);
    imem[6] = e_j(32'hFFFF_FFEC, 5'd6);
    go(cyc);
    chk("R7 forward link", dmem[0], 32'd4);
    chk("R7 backward link", dmem[1], 32'd28);
    chk("R7 path", dmem[2], 32'd7);
    chk("R7 cycles", cyc, 7);

    // R8: near-miss illegal encodings
    bad[0]  = e_r(7'h01, 5'd2, 5'd2, 3'b000, 5'd2);
    bad[1]  = e_r(7'h20, 5'd2, 5'd2, 3'b111, 5'd2);
    bad[2]  = e_i(1, 5'd2, 3'b001, 5'd2, 7'h13);
    bad[3]  = e_i(4, 5'd0, 3'b000, 5'd2, 7'h03);
    bad[4]  = e_s(4, 5'd2, 5'd0, 3'b000);
    bad[5]  = e_b(8, 5'd0, 5'd0, 3'b100);
    bad[6]  = {20'h1, 5'd2, 7'h17};
    bad[7]  = 32'h0000_0073;
    bad[8]  = 32'h0010_00F3;
    bad[9]  = 32'h0;
    bad[10] = e_i(0, 5'd0, 3'b000, 5'd2, 7'h67);
    for (int k = 0; k < 11; k++) begin
      begin_prog();
      imem[0] = addi(5'd2, 5'd0, 11);
      imem[1] = bad[k];
      imem[2] = sw(5'd2, 5'd0, 0);
      imem[3] = STOP;
      go(cyc);
      chk("R8 fault raised", {30'b0, halted, fault}, 32'h1);
      chk("R8 no store", n_st, 0);
      chk("R8 pc at bad word", fetch_addr, 32'd4);
      chk("R8 memory intact", dmem[1], 32'hA500_0001);
      hold_check();
    end

    // R9 R10: alignment of addresses and targets
    mw[0] = lw(5'd2, 5'd0, 1);                mf[0] = 1; m0[0] = 32'hA500_0000;
    mw[1] = lw(5'd2, 5'd2, 32'hFFFF_FFF9);    mf[1] = 0; m0[1] = 32'hA500_0001;
    mw[2] = sw(5'd2, 5'd0, 2);                mf[2] = 1; m0[2] = 32'hA500_0000;
    mw[3] = sw(5'd2, 5'd2, 32'hFFFF_FFF7);    mf[3] = 1; m0[3] = 32'hA500_0000;
    mw[4] = e_b(6, 5'd0, 5'd0, 3'b000);       mf[4] = 1; m0[4] = 32'hA500_0000;
    mw[5] = e_b(6, 5'd0, 5'd0, 3'b001);       mf[5] = 0; m0[5] = 32'd11;
    mw[6] = e_b(6, 5'd0, 5'd2, 3'b000);       mf[6] = 0; m0[6] = 32'd11;
    mw[7] = e_j(10, 5'd2);                    mf[7] = 1; m0[7] = 32'hA500_0000;
    mw[8] = e_j(8, 5'd0);                     mf[8] = 0; m0[8] = 32'hA500_0000;
    for (int k = 0; k < 9; k++) begin
      begin_prog();
      imem[0] = addi(5'd2, 5'd0, 11);
      imem[1] = mw[k];
      imem[2] = sw(5'd2, 5'd0, 0);
      imem[3] = STOP;
      go(cyc);
      if (k == 0 || k == 1 || k == 2 || k == 3) begin
        chk("R9 flags", {30'b0, halted, fault}, {30'b0, !mf[k], mf[k]});
        chk("R9 memory word 0", dmem[0], m0[k]);
      end else begin
        chk("R10 flags", {30'b0, halted, fault}, {30'b0, !mf[k], mf[k]});
        chk("R10 memory word 0", dmem[0], m0[k]);
      end
      chk("R9 R10 stop pc", fetch_addr, mf[k] ? 32'd4 : 32'd12);
      hold_check();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule